// File: doc/BRIEF.md
# SD Card Block Receive Path

This block is the card-to-host data side of an SD/MMC host controller. Control logic arms it with a byte count, a block-size exponent, a bus-width selection and a wait limit. It then follows the data lines one SD clock tick at a time. A tick is a one-cycle `sd_tick` strobe in the system clock domain. For each block, the block waits for a start bit, collects the payload, and checks a separate CRC16 on every active data line. The received bytes are packed into 32-bit words and placed in a 16-word receive FIFO.

The FIFO drains through a valid/ready port. `rd_valid` is high whenever the FIFO holds a word. A word leaves in the cycle where `rd_valid` and `rd_ready` are both high. While `rd_ready` stays low, the head word and `rd_valid` do not change, and incoming words keep filling the FIFO. The receive side cannot be stalled, so a word that arrives when all 16 entries are occupied is lost and recorded as an overrun. Status outputs report per-block and whole-transfer completion, CRC failure, timeout, overrun, FIFO level and activity, together with the live count of bytes still expected.

Top module: `sdrx_path`

## Requirements
- R1: A `cfg_start` pulse with `cfg_dir_rx`=1 while idle loads `st_remain` from `cfg_len` and raises `st_active`. A pulse with `cfg_dir_rx`=0 has no effect.
- R2: `cfg_wid_sel` selects the lines: bit 1 set means 8 lines, else bit 0 set means 4 lines, else 1 line. With 1 line, `sd_dat[0]` carries each byte MSB first over 8 ticks. With 4 lines, `sd_dat[3:0]` carries the high nibble, then the low nibble. With 8 lines, `sd_dat[7:0]` carries one byte per tick.
- R3: `st_remain` drops by one per payload byte. When the final block's CRC passes with `st_remain` at 0, `st_xfer_end` sets and `st_active` falls.
- R4: A block holds 2^`cfg_blk_exp` bytes and starts on the first tick with `sd_dat[0]`=0. `st_blk_end` sets on the tick after the 16 CRC ticks of a block whose CRC matched on all active lines.
- R5: Each active line carries CRC16 (polynomial 0x1021, initial value 0, MSB first) of its own payload bits, followed by a one-tick end bit. A mismatch on any active line sets `st_crc_fail`, withholds `st_blk_end`, and ends the transfer.
- R6: While the block waits for a start bit, the (`cfg_tmo`+1)-th consecutive tick without one sets `st_timeout` and ends the transfer.
- R7: Bytes fill words little-endian, with the first byte in bits 7:0. The last word of a transfer is pushed even when it is partial, and its unfilled bytes read as zero.
- R8: A `cfg_fifo_flush` pulse empties the FIFO. After it, `st_fifo_empty`=1 and `rd_valid`=0.
- R9: `st_fifo_half` is high while the FIFO holds at least 8 words. `st_fifo_empty` is high while it holds none.
- R10: A word completed while the FIFO holds 16 entries is dropped and sets `st_overrun`. The stored words are kept.
- R11: `rd_valid` equals "FIFO not empty". A word is removed only when `rd_valid` and `rd_ready` are both high. The oldest word is presented first, and `rd_data` holds while it waits.
- R12: The flags `st_blk_end`, `st_xfer_end`, `st_crc_fail`, `st_timeout` and `st_overrun` stay set until a `cfg_clr_flags` pulse clears them. All status reads zero out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Arm pulse |
| cfg_dir_rx | input | 1 | Card-to-host direction select |
| cfg_len | input | LEN_W | Total transfer byte count |
| cfg_blk_exp | input | 4 | Block size exponent |
| cfg_wid_sel | input | 2 | Bus width select |
| cfg_tmo | input | TMO_W | Start-bit wait limit in ticks |
| cfg_fifo_flush | input | 1 | Empties the FIFO |
| cfg_clr_flags | input | 1 | Clears sticky flags |
| sd_tick | input | 1 | One strobe per SD clock |
| sd_dat | input | 8 | Data lines sampled on `sd_tick` |
| rd_valid | output | 1 | FIFO word available |
| rd_ready | input | 1 | Reader accepts word |
| rd_data | output | 32 | FIFO head word |
| st_blk_end | output | 1 | Block received with good CRC |
| st_xfer_end | output | 1 | Transfer complete |
| st_crc_fail | output | 1 | CRC mismatch |
| st_timeout | output | 1 | Start bit not seen in time |
| st_overrun | output | 1 | Word lost to full FIFO |
| st_fifo_half | output | 1 | At least 8 words stored |
| st_fifo_empty | output | 1 | No words stored |
| st_active | output | 1 | Transfer in progress |
| st_remain | output | LEN_W | Bytes still expected |

## Verification
Two situations are hard to reach from the ports. The first is a CRC mismatch on one line while the other lines are correct. The bench builds each frame with its own per-line CRC model and flips a single CRC bit on line 2 of a 4-line block. The second is an overrun. The bench holds `rd_ready` low through a 128-byte, 8-line block so that the 32 words overfill the 16-entry FIFO, then checks that the first 16 words survive intact. Randomised transfers then cover all three widths and block sizes from 1 to 32 bytes, including sizes that leave a partial last word.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
  localparam int unsigned LINES    = 8;
  localparam int unsigned CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {LANES_1, LANES_4, LANES_8} lanes_e;
  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_DATA, ST_CRC, ST_STOP} rx_state_e;

  function automatic lanes_e decode_width(input logic [1:0] sel);
    if (sel[1])      return LANES_8;
    else if (sel[0]) return LANES_4;
    else             return LANES_1;
  endfunction

  function automatic logic [LINES-1:0] lane_mask(input lanes_e l);
    case (l)
      LANES_8: return 8'hFF;
      LANES_4: return 8'h0F;
      default: return 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/sdrx_crc16.sv
module sdrx_crc16
  import sdrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_q
);
  logic fb;
  assign fb = crc_q[CRC_W-1] ^ bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (en)  crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end
endmodule

// File: rtl/sdrx_ctrl.sv
module sdrx_ctrl
  import sdrx_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned TMO_W = 16,
  parameter int unsigned EXP_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm_req,
  input  logic                        arm_dir,
  input  logic [LEN_W-1:0]            len_in,
  input  logic [EXP_W-1:0]            exp_in,
  input  logic [1:0]                  wid_in,
  input  logic [TMO_W-1:0]            tmo_in,
  input  logic                        clr_flags,
  input  logic                        ovr_evt,
  input  logic                        sd_tick,
  input  logic [LINES-1:0]            sd_dat,
  input  logic [LINES-1:0][CRC_W-1:0] crc_val,
  output logic                        arm_ok,
  output logic                        crc_clr,
  output logic                        crc_en,
  output logic                        byte_valid,
  output logic [7:0]                  byte_data,
  output logic                        byte_last,
  output logic [LEN_W-1:0]            remain,
  output logic                        active,
  output logic                        f_blk_end,
  output logic                        f_xfer_end,
  output logic                        f_crc_fail,
  output logic                        f_timeout,
  output logic                        f_overrun
);
  localparam int unsigned BLK_W = 1 << EXP_W;

  rx_state_e         state_q;
  lanes_e            lanes_q;
  logic [EXP_W-1:0]  exp_q;
  logic [TMO_W-1:0]  tmo_q, wait_q;
  logic [BLK_W-1:0]  blk_q, blk_last;
  logic [2:0]        sub_q;
  logic [3:0]        idx_q;
  logic [7:0]        sh_q, nxt_byte;
  logic              sub_last, miss_q;
  logic [LINES-1:0]  exp_bits, mask;

  logic ev_blk, ev_xfer, ev_crc, ev_tmo;

  assign blk_last = (BLK_W'(1) << exp_q) - BLK_W'(1);
  assign mask     = lane_mask(lanes_q);
  assign active   = (state_q != ST_IDLE);
  assign arm_ok   = arm_req && arm_dir && (state_q == ST_IDLE);
  assign crc_en   = sd_tick && (state_q == ST_DATA);
  assign crc_clr  = sd_tick && (state_q == ST_WAIT) && !sd_dat[0];

  always_comb begin
    for (int i = 0; i < LINES; i++) exp_bits[i] = crc_val[i][~idx_q];
  end

  always_comb begin
    case (lanes_q)
      LANES_8: begin nxt_byte = sd_dat;                   sub_last = 1'b1;         end
      LANES_4: begin nxt_byte = {sh_q[3:0], sd_dat[3:0]}; sub_last = (sub_q == 3'd1); end
      default: begin nxt_byte = {sh_q[6:0], sd_dat[0]};   sub_last = (sub_q == 3'd7); end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; lanes_q <= LANES_1; exp_q <= '0; tmo_q <= '0;
      wait_q <= '0; blk_q <= '0; sub_q <= '0; idx_q <= '0; sh_q <= '0;
      miss_q <= 1'b0; remain <= '0; byte_valid <= 1'b0; byte_data <= '0;
      byte_last <= 1'b0; ev_blk <= 1'b0; ev_xfer <= 1'b0; ev_crc <= 1'b0;
      ev_tmo <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      ev_blk <= 1'b0; ev_xfer <= 1'b0; ev_crc <= 1'b0; ev_tmo <= 1'b0;
      if (arm_ok) begin
        remain  <= len_in;
        lanes_q <= decode_width(wid_in);
        exp_q   <= exp_in;
        tmo_q   <= tmo_in;
        wait_q  <= '0;
        state_q <= ST_WAIT;
      end else if (sd_tick) begin
        case (state_q)
          ST_WAIT: begin
            if (!sd_dat[0]) begin
              state_q <= ST_DATA; miss_q <= 1'b0; sub_q <= '0; blk_q <= '0;
            end else if (wait_q == tmo_q) begin
              ev_tmo <= 1'b1; state_q <= ST_IDLE;
            end else begin
              wait_q <= wait_q + TMO_W'(1);
            end
          end
          ST_DATA: begin
            sh_q <= nxt_byte;
            if (sub_last) begin
              sub_q      <= '0;
              byte_valid <= 1'b1;
              byte_data  <= nxt_byte;
              byte_last  <= (remain == LEN_W'(1));
              remain     <= remain - LEN_W'(1);
              if ((blk_q == blk_last) || (remain == LEN_W'(1))) begin
                state_q <= ST_CRC; idx_q <= '0;
              end else begin
                blk_q <= blk_q + BLK_W'(1);
              end
            end else begin
              sub_q <= sub_q + 3'd1;
            end
          end
          ST_CRC: begin
            if (|((sd_dat ^ exp_bits) & mask)) miss_q <= 1'b1;
            if (idx_q == 4'd15) state_q <= ST_STOP;
            idx_q <= idx_q + 4'd1;
          end
          ST_STOP: begin
            if (miss_q) begin
              ev_crc <= 1'b1; state_q <= ST_IDLE;
            end else begin
              ev_blk <= 1'b1;
              if (remain == '0) begin
                ev_xfer <= 1'b1; state_q <= ST_IDLE;
              end else begin
                state_q <= ST_WAIT; wait_q <= '0;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_blk_end <= 1'b0; f_xfer_end <= 1'b0; f_crc_fail <= 1'b0;
      f_timeout <= 1'b0; f_overrun <= 1'b0;
    end else begin
      if (clr_flags) begin
        f_blk_end <= 1'b0; f_xfer_end <= 1'b0; f_crc_fail <= 1'b0;
        f_timeout <= 1'b0; f_overrun <= 1'b0;
      end
      if (ev_blk)  f_blk_end  <= 1'b1;
      if (ev_xfer) f_xfer_end <= 1'b1;
      if (ev_crc)  f_crc_fail <= 1'b1;
      if (ev_tmo)  f_timeout  <= 1'b1;
      if (ovr_evt) f_overrun  <= 1'b1;
    end
  end
endmodule

// File: rtl/sdrx_packer.sv
module sdrx_packer #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              byte_last,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam int unsigned NB   = WORD_W / 8;
  localparam int unsigned IDXW = (NB > 1) ? $clog2(NB) : 1;

  logic [WORD_W-1:0] acc_q, merged;
  logic [IDXW-1:0]   idx_q;

  always_comb begin
    merged = acc_q;
    merged[idx_q*8 +: 8] = byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; idx_q <= '0; word_valid <= 1'b0; word_data <= '0;
    end else begin
      word_valid <= 1'b0;
      if (clr) begin
        acc_q <= '0; idx_q <= '0;
      end else if (byte_valid) begin
        if ((idx_q == IDXW'(NB-1)) || byte_last) begin
          word_valid <= 1'b1;
          word_data  <= merged;
          acc_q      <= '0;
          idx_q      <= '0;
        end else begin
          acc_q <= merged;
          idx_q <= idx_q + IDXW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdrx_fifo.sv
module sdrx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         drop,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         half,
  output logic         empty
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned CW   = AW + 1;
  localparam int unsigned HALF = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign half     = (cnt >= CW'(HALF));
  assign rd_valid = !empty;
  assign rd_data  = mem[rptr];
  assign do_pop   = rd_valid && rd_ready && !flush;
  assign do_push  = push && !full && !flush;
  assign drop     = push && full && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else if (flush) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sdrx_path.sv
module sdrx_path
  import sdrx_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned TMO_W      = 16,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_start,
  input  logic             cfg_dir_rx,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [3:0]       cfg_blk_exp,
  input  logic [1:0]       cfg_wid_sel,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             cfg_fifo_flush,
  input  logic             cfg_clr_flags,
  input  logic             sd_tick,
  input  logic [7:0]       sd_dat,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [31:0]      rd_data,
  output logic             st_blk_end,
  output logic             st_xfer_end,
  output logic             st_crc_fail,
  output logic             st_timeout,
  output logic             st_overrun,
  output logic             st_fifo_half,
  output logic             st_fifo_empty,
  output logic             st_active,
  output logic [LEN_W-1:0] st_remain
);
  localparam int unsigned WORD_W = 32;

  logic [LINES-1:0][CRC_W-1:0] crc_val;
  logic              arm_ok, crc_clr, crc_en;
  logic              byte_valid, byte_last, word_valid, drop;
  logic [7:0]        byte_data;
  logic [WORD_W-1:0] word_data;

  for (genvar g = 0; g < LINES; g++) begin : g_lane
    sdrx_crc16 u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
      .bit_in(sd_dat[g]), .crc_q(crc_val[g])
    );
  end

  sdrx_ctrl #(.LEN_W(LEN_W), .TMO_W(TMO_W), .EXP_W(4)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .arm_req(cfg_start), .arm_dir(cfg_dir_rx), .len_in(cfg_len),
    .exp_in(cfg_blk_exp), .wid_in(cfg_wid_sel), .tmo_in(cfg_tmo),
    .clr_flags(cfg_clr_flags), .ovr_evt(drop),
    .sd_tick(sd_tick), .sd_dat(sd_dat), .crc_val(crc_val),
    .arm_ok(arm_ok), .crc_clr(crc_clr), .crc_en(crc_en),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
    .remain(st_remain), .active(st_active),
    .f_blk_end(st_blk_end), .f_xfer_end(st_xfer_end),
    .f_crc_fail(st_crc_fail), .f_timeout(st_timeout), .f_overrun(st_overrun)
  );

  sdrx_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(arm_ok),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
    .word_valid(word_valid), .word_data(word_data)
  );

  sdrx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cfg_fifo_flush),
    .push(word_valid), .push_data(word_data), .drop(drop),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .half(st_fifo_half), .empty(st_fifo_empty)
  );
endmodule

// File: rtl/sdrx_path_chk.sv
module sdrx_path_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_start,
  input logic             cfg_dir_rx,
  input logic             cfg_fifo_flush,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [31:0]      rd_data,
  input logic             st_xfer_end,
  input logic             st_crc_fail,
  input logic             st_timeout,
  input logic             st_fifo_half,
  input logic             st_fifo_empty,
  input logic             st_active,
  input logic [LEN_W-1:0] st_remain
);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_active && !(cfg_start && cfg_dir_rx)) |=> $stable(st_remain));

  a_r3_remain_step: assert property (@(posedge clk) disable iff (!rst_n)
    st_active |=> (st_remain == $past(st_remain)) ||
                  (st_remain == $past(st_remain) - LEN_W'(1)));

  a_r3_end_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_xfer_end) |-> (st_remain == '0) && !st_active);

  a_r5_crc_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_crc_fail) |-> !st_active);

  a_r6_timeout_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_timeout) |-> !st_active);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fifo_flush |=> st_fifo_empty && !rd_valid);

  a_r9_half_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    st_fifo_half |-> !st_fifo_empty);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !cfg_fifo_flush) |=> rd_valid && $stable(rd_data));
endmodule

bind sdrx_path sdrx_path_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_dir_rx(cfg_dir_rx),
  .cfg_fifo_flush(cfg_fifo_flush), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .st_xfer_end(st_xfer_end), .st_crc_fail(st_crc_fail),
  .st_timeout(st_timeout), .st_fifo_half(st_fifo_half),
  .st_fifo_empty(st_fifo_empty), .st_active(st_active), .st_remain(st_remain)
);

// File: tb/sim_sdrx_path.sv
module sim_sdrx_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 0, cfg_dir_rx = 0, cfg_fifo_flush = 0, cfg_clr_flags = 0;
  logic [15:0] cfg_len = 0, cfg_tmo = 0;
  logic [3:0]  cfg_blk_exp = 0;
  logic [1:0]  cfg_wid_sel = 0;
  logic        sd_tick = 0, rd_ready = 0;
  logic [7:0]  sd_dat = 8'hFF;
  logic        rd_valid, st_blk_end, st_xfer_end, st_crc_fail, st_timeout;
  logic        st_overrun, st_fifo_half, st_fifo_empty, st_active;
  logic [31:0] rd_data;
  logic [15:0] st_remain;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] pay [0:255];

  always #2.5 clk = ~clk;

  sdrx_path u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  function automatic int lanes_of(input logic [1:0] s);
    return s[1] ? 8 : (s[0] ? 4 : 1);
  endfunction

  function automatic logic [31:0] exp_word(input int k, input int len);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4*k + j < len) w[8*j +: 8] = pay[4*k + j];
    return w;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic [7:0] d);
    @(negedge clk); sd_dat = d; sd_tick = 1'b1;
    @(negedge clk); sd_tick = 1'b0; sd_dat = 8'hFF;
  endtask

  task automatic pulse_clr();
    @(negedge clk); cfg_clr_flags = 1'b1; @(negedge clk); cfg_clr_flags = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); cfg_fifo_flush = 1'b1; @(negedge clk); cfg_fifo_flush = 1'b0;
  endtask

  task automatic arm(input int len, input int ex, input logic [1:0] ws, input int tmo, input logic dir);
    @(negedge clk);
    cfg_len = 16'(len); cfg_blk_exp = 4'(ex); cfg_wid_sel = ws; cfg_tmo = 16'(tmo);
    cfg_dir_rx = dir; cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
  endtask

  task automatic send_block(input int off, input int nb, input int w, input int bad_line);
    logic [15:0] crc [8];
    logic [7:0]  bt, d;
    for (int i = 0; i < 8; i++) crc[i] = 16'h0;
    tick(8'hFF); tick(8'hFF); tick(8'h00);
    for (int b = 0; b < nb; b++) begin
      bt = pay[off + b];
      for (int t = 0; t < 8 / w; t++) begin
        if (w == 1)      d = {7'h7F, bt[7 - t]};
        else if (w == 4) d = {4'hF, (t == 0) ? bt[7:4] : bt[3:0]};
        else             d = bt;
        for (int i = 0; i < w; i++) crc[i] = crc_step(crc[i], d[i]);
        tick(d);
      end
    end
    for (int k = 0; k < 16; k++) begin
      d = 8'hFF;
      for (int i = 0; i < w; i++) d[i] = crc[i][15 - k];
      if (bad_line >= 0 && k == 3) d[bad_line] = ~d[bad_line];
      tick(d);
    end
    tick(8'hFF);
  endtask

  task automatic pop_word(output logic v, output logic [31:0] w);
    @(negedge clk);
    v = rd_valid; w = rd_data; rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic drain_check(input int len, input int nw, input string req);
    logic v; logic [31:0] w;
    for (int k = 0; k < nw; k++) begin
      pop_word(v, w);
      chk(v && (w == exp_word(k, len)), req, w, exp_word(k, len));
    end
  endtask

  task automatic run_xfer(input int len, input int ex, input logic [1:0] ws, input string req);
    int nb = 1 << ex;
    arm(len, ex, ws, 1000, 1'b1);
    for (int off = 0; off < len; off += nb) send_block(off, nb, lanes_of(ws), -1);
    wait_clk(6);
    chk(st_xfer_end && st_blk_end && !st_active, {req, " R3 end"}, {st_xfer_end, st_active}, 2'b10);
    drain_check(len, (len + 3) / 4, {req, " R7 words"});
    chk(st_fifo_empty && !rd_valid, {req, " R11 drained"}, st_fifo_empty, 1);
    pulse_clr();
  endtask

  initial begin
    logic v; logic [31:0] w, held;
    void'($urandom(32'h5D17));
    wait_clk(3); rst_n = 1'b1; wait_clk(2);

    // R12 reset state
    chk(!st_active && st_fifo_empty && !rd_valid && st_remain == 0, "R12 reset", {st_active, st_fifo_empty}, 2'b01);
    chk({st_blk_end, st_xfer_end, st_crc_fail, st_timeout, st_overrun} == 0, "R12 flags", 0, 0);

    // R1 direction 0 ignored
    arm(40, 2, 2'b01, 10, 1'b0);
    wait_clk(2);
    chk(!st_active && st_remain == 0, "R1 dir ignored", st_remain, 0);

    // R1 R2 R3 R4: 4 lines, 4-byte blocks, 2 blocks
    for (int i = 0; i < 8; i++) pay[i] = 8'(8'h11 * (i + 1));
    arm(8, 2, 2'b01, 100, 1'b1);
    wait_clk(1);
    chk(st_active && st_remain == 8, "R1 arm", st_remain, 8);
    send_block(0, 4, 4, -1);
    wait_clk(2);
    chk(st_remain == 4 && st_blk_end && !st_xfer_end && st_active, "R4 first block", st_remain, 4);
    send_block(4, 4, 4, -1);
    wait_clk(4);
    chk(st_xfer_end && !st_active && st_remain == 0, "R3 transfer end", st_remain, 0);
    drain_check(8, 2, "R2 R7 4-line words");
    pulse_clr();
    chk(!st_blk_end && !st_xfer_end, "R12 clear", {st_blk_end, st_xfer_end}, 0);

    // R7 partial word, R4 one-byte blocks, 8 lines
    pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3;
    run_xfer(3, 0, 2'b10, "R7 partial");

    // R5 CRC fail on line 2
    for (int i = 0; i < 8; i++) pay[i] = 8'($urandom);
    arm(16, 3, 2'b01, 100, 1'b1);
    send_block(0, 8, 4, 2);
    wait_clk(3);
    chk(st_crc_fail && !st_blk_end && !st_active, "R5 crc fail", {st_crc_fail, st_blk_end, st_active}, 3'b100);
    pulse_clr();
    chk(!st_crc_fail, "R12 crc clear", st_crc_fail, 0);

    // R8 flush
    chk(!st_fifo_empty, "R8 data present", st_fifo_empty, 0);
    pulse_flush();
    chk(st_fifo_empty && !rd_valid, "R8 flush", rd_valid, 0);

    // R6 timeout after tmo+1 ticks
    arm(8, 2, 2'b00, 5, 1'b1);
    for (int i = 0; i < 5; i++) tick(8'hFF);
    wait_clk(1);
    chk(!st_timeout && st_active, "R6 not yet", st_timeout, 0);
    tick(8'hFF);
    wait_clk(1);
    chk(st_timeout && !st_active, "R6 timeout", st_timeout, 1);
    pulse_clr();

    // R9 R11 half flag and hold
    for (int i = 0; i < 32; i++) pay[i] = 8'($urandom);
    arm(32, 5, 2'b10, 100, 1'b1);
    send_block(0, 32, 8, -1);
    wait_clk(4);
    chk(st_fifo_half && !st_fifo_empty, "R9 half", st_fifo_half, 1);
    held = rd_data;
    wait_clk(5);
    chk(rd_valid && rd_data == held && rd_data == exp_word(0, 32), "R11 hold", rd_data, exp_word(0, 32));
    pop_word(v, w);
    chk(v && w == exp_word(0, 32), "R11 first pop", w, exp_word(0, 32));
    chk(!st_fifo_half, "R9 below half", st_fifo_half, 0);
    for (int k = 1; k < 8; k++) begin
      pop_word(v, w);
      chk(v && w == exp_word(k, 32), "R11 order", w, exp_word(k, 32));
    end
    chk(st_fifo_empty, "R9 empty", st_fifo_empty, 1);
    pulse_clr();

    // R10 overrun: 32 words into 16 entries
    for (int i = 0; i < 128; i++) pay[i] = 8'($urandom);
    arm(128, 7, 2'b10, 100, 1'b1);
    send_block(0, 128, 8, -1);
    wait_clk(4);
    chk(st_overrun && st_xfer_end, "R10 overrun", st_overrun, 1);
    drain_check(128, 16, "R10 kept words");
    chk(st_fifo_empty, "R10 rest dropped", st_fifo_empty, 1);
    pulse_clr();

    // random transfers across widths (R2 R4 R7)
    for (int it = 0; it < 9; it++) begin
      int ex, nblk, mx;
      ex = $urandom_range(0, 5);
      mx = 64 >> ex; if (mx > 4) mx = 4;
      nblk = $urandom_range(1, mx);
      for (int i = 0; i < (nblk << ex); i++) pay[i] = 8'($urandom);
      run_xfer(nblk << ex, ex, 2'(it % 3), "R2 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule